// File: doc/BRIEF.md
# Vertical Laplacian Sharpening Datapath

This block sharpens a raster image along the slow-scan axis, which runs from line to line. On each clock it takes three pixels from the same column of three adjacent lines. The incoming line is the lower neighbour. A one-line delayed copy gives the pixel being corrected. A two-line delayed copy gives the upper neighbour. The line stores that supply these streams sit outside the block.

The datapath has three stages. Stage one forms the sum of the two neighbours and doubles the centre pixel. Stage two forms the signed second difference and scales it by a gain. Stage three rounds the scaled value, adds it back to the centre pixel and clamps the result to the pixel range. The corrected pixel is N' = N + K·(2N − (A + B)).

The gain is a programmable unsigned fixed-point value. A one-bit valid flag travels alongside the data. A gain of zero passes the centre pixel through unchanged, and larger gains give a stronger edge boost across lines.

Top module: `vlap_sharpen`

## Requirements
- R1: `out_valid` equals `in_valid` from exactly 3 clocks earlier; one input accepted per clock gives one result per clock.
- R2: For a valid input with upper pixel A (`pix_d2`), centre N (`pix_d1`), lower B (`pix_cur`) and gain K (`gain_k`, unsigned, 4 integer and 4 fractional bits, value = `gain_k`/16), `pix_out` = clamp(N + round((2N − A − B)·`gain_k`/16)).
- R3: Rounding is to nearest, with an exact half rounded towards plus infinity: +0.5 becomes +1, −0.5 becomes 0, +1.5 becomes +2.
- R4: A result above 255 is clamped to 255 (for example N=255, A=B=0, `gain_k`=16 gives 255).
- R5: A result below 0 is clamped to 0 (for example N=0, A=B=255, `gain_k`=16 gives 0).
- R6: When `gain_k` is 0, `pix_out` equals N exactly, whatever the neighbours are.
- R7: Each pixel uses the gain present in its own input cycle. A change of `gain_k` in a later cycle does not alter that pixel's result.
- R8: While `out_valid` is low, `pix_out` keeps its previous value.
- R9: While reset is applied, and at its release, `out_valid` is 0 and `pix_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | The pixel triple on this clock is valid |
| pix_cur | input | 8 | Current line pixel (lower neighbour B) |
| pix_d1 | input | 8 | One-line delayed pixel (centre N, corrected) |
| pix_d2 | input | 8 | Two-line delayed pixel (upper neighbour A) |
| gain_k | input | 8 | Sharpening gain, unsigned 4.4 fixed point |
| out_valid | output | 1 | `pix_out` carries a new result |
| pix_out | output | 8 | Corrected centre pixel |

## Verification
Rounding and clamping can both act on the same pixel. The clearest case is a large positive difference scaled by a fractional gain whose rounded sum overshoots 255, or a negative one that undershoots 0. The bench drives corner triples that make both happen together, and also exact half products near zero, and compares each result with an integer model of the formula. A gain change that lands in the same window as a pixel still in the pipeline is provoked by changing `gain_k` one clock after the pixel is accepted. The bench then checks that the result follows the earlier gain.

// File: rtl/vlap_pkg.sv
package vlap_pkg;

  localparam int unsigned DEF_PIX_W  = 8;
  localparam int unsigned DEF_K_INT  = 4;
  localparam int unsigned DEF_K_FRAC = 4;
  localparam int unsigned PIPE_DEPTH = 3;

  // width of the signed second difference 2N - (A + B)
  function automatic int unsigned diff_width(int unsigned pix_w);
    return pix_w + 2;
  endfunction

  // width of the signed difference times the zero-extended gain
  function automatic int unsigned prod_width(int unsigned pix_w, int unsigned k_w);
    return pix_w + 2 + k_w + 1;
  endfunction

endpackage

// File: rtl/vlap_rst_sync.sv
module vlap_rst_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [SYNC_STAGES-1:0] chain_q;
  logic [SYNC_STAGES-1:0] chain_d;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_comb chain_d = 1'b1;
    end else begin : g_multi
      always_comb chain_d = {chain_q[SYNC_STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_o = chain_q[SYNC_STAGES-1];

endmodule

// File: rtl/vlap_sum_stage.sv
module vlap_sum_stage #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned K_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] pix_up,
  input  logic [PIX_W-1:0] pix_mid,
  input  logic [PIX_W-1:0] pix_low,
  input  logic [K_W-1:0]   gain,
  output logic             s1_valid,
  output logic [PIX_W:0]   s1_nsum,
  output logic [PIX_W:0]   s1_twice,
  output logic [PIX_W-1:0] s1_mid,
  output logic [K_W-1:0]   s1_gain
);

  logic [PIX_W:0] nsum_d;
  logic [PIX_W:0] twice_d;
  logic           load_en;

  always_comb begin
    load_en = in_valid;
    nsum_d  = {1'b0, pix_up} + {1'b0, pix_low};
    twice_d = {pix_mid, 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_nsum  <= '0;
      s1_twice <= '0;
      s1_mid   <= '0;
      s1_gain  <= '0;
    end else begin
      s1_valid <= in_valid;
      if (load_en) begin
        s1_nsum  <= nsum_d;
        s1_twice <= twice_d;
        s1_mid   <= pix_mid;
        s1_gain  <= gain;
      end
    end
  end

endmodule

// File: rtl/vlap_scale_stage.sv
module vlap_scale_stage #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned K_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s1_valid,
  input  logic [PIX_W:0]   s1_nsum,
  input  logic [PIX_W:0]   s1_twice,
  input  logic [PIX_W-1:0] s1_mid,
  input  logic [K_W-1:0]   s1_gain,
  output logic             s2_valid,
  output logic signed [vlap_pkg::prod_width(PIX_W, K_W)-1:0] s2_prod,
  output logic [PIX_W-1:0] s2_mid
);

  localparam int unsigned DIFF_W = vlap_pkg::diff_width(PIX_W);
  localparam int unsigned PROD_W = vlap_pkg::prod_width(PIX_W, K_W);

  logic signed [DIFF_W-1:0] diff_d;
  logic signed [PROD_W-1:0] diff_x;
  logic signed [PROD_W-1:0] gain_x;
  logic signed [PROD_W-1:0] prod_d;
  logic                     load_en;

  always_comb begin
    load_en = s1_valid;
    diff_d  = $signed({1'b0, s1_twice}) - $signed({1'b0, s1_nsum});
    diff_x  = {{(PROD_W-DIFF_W){diff_d[DIFF_W-1]}}, diff_d};
    gain_x  = $signed({{(PROD_W-K_W){1'b0}}, s1_gain});
    prod_d  = diff_x * gain_x;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_prod  <= '0;
      s2_mid   <= '0;
    end else begin
      s2_valid <= s1_valid;
      if (load_en) begin
        s2_prod <= prod_d;
        s2_mid  <= s1_mid;
      end
    end
  end

endmodule

// File: rtl/vlap_round_clamp.sv
module vlap_round_clamp #(
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned K_FRAC = 4,
  parameter int unsigned PROD_W = 19
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     s2_valid,
  input  logic signed [PROD_W-1:0] s2_prod,
  input  logic [PIX_W-1:0]         s2_mid,
  output logic                     s3_valid,
  output logic [PIX_W-1:0]         s3_pix
);

  localparam int unsigned EXT_W = PROD_W + 1;
  localparam int unsigned TOT_W = PROD_W + 2;
  localparam logic signed [EXT_W-1:0] HALF_LSB =
    (K_FRAC == 0) ? '0 : EXT_W'(1) << (K_FRAC - 1);
  localparam logic signed [TOT_W-1:0] PIX_MAX = TOT_W'((1 << PIX_W) - 1);

  logic signed [EXT_W-1:0] biased;
  logic signed [EXT_W-1:0] scaled;
  logic signed [TOT_W-1:0] total;
  logic [PIX_W-1:0]        pix_d;
  logic                    load_en;

  always_comb begin
    load_en = s2_valid;
    biased  = {s2_prod[PROD_W-1], s2_prod} + HALF_LSB;
    scaled  = biased >>> K_FRAC;
    total   = {scaled[EXT_W-1], scaled} +
              $signed({{(TOT_W-PIX_W){1'b0}}, s2_mid});
    if (total < 0) begin
      pix_d = '0;
    end else if (total > PIX_MAX) begin
      pix_d = '1;
    end else begin
      pix_d = total[PIX_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s3_valid <= 1'b0;
      s3_pix   <= '0;
    end else begin
      s3_valid <= s2_valid;
      if (load_en) begin
        s3_pix <= pix_d;
      end
    end
  end

endmodule

// File: rtl/vlap_sharpen.sv
module vlap_sharpen #(
  parameter int unsigned PIX_W       = vlap_pkg::DEF_PIX_W,
  parameter int unsigned K_INT       = vlap_pkg::DEF_K_INT,
  parameter int unsigned K_FRAC      = vlap_pkg::DEF_K_FRAC,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [PIX_W-1:0]        pix_cur,
  input  logic [PIX_W-1:0]        pix_d1,
  input  logic [PIX_W-1:0]        pix_d2,
  input  logic [K_INT+K_FRAC-1:0] gain_k,
  output logic                    out_valid,
  output logic [PIX_W-1:0]        pix_out
);

  localparam int unsigned K_W    = K_INT + K_FRAC;
  localparam int unsigned PROD_W = vlap_pkg::prod_width(PIX_W, K_W);

  logic                     rst_int_n;
  logic                     s1_valid;
  logic [PIX_W:0]           s1_nsum;
  logic [PIX_W:0]           s1_twice;
  logic [PIX_W-1:0]         s1_mid;
  logic [K_W-1:0]           s1_gain;
  logic                     s2_valid;
  logic signed [PROD_W-1:0] s2_prod;
  logic [PIX_W-1:0]         s2_mid;

  vlap_rst_sync #(.SYNC_STAGES(SYNC_STAGES)) u_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_int_n)
  );

  // stage 1: neighbour sum and doubled centre; lower = current, upper = 2-line
  vlap_sum_stage #(.PIX_W(PIX_W), .K_W(K_W)) u_sum (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .in_valid (in_valid),
    .pix_up   (pix_d2),
    .pix_mid  (pix_d1),
    .pix_low  (pix_cur),
    .gain     (gain_k),
    .s1_valid (s1_valid),
    .s1_nsum  (s1_nsum),
    .s1_twice (s1_twice),
    .s1_mid   (s1_mid),
    .s1_gain  (s1_gain)
  );

  // stage 2: signed second difference times gain
  vlap_scale_stage #(.PIX_W(PIX_W), .K_W(K_W)) u_scale (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .s1_valid (s1_valid),
    .s1_nsum  (s1_nsum),
    .s1_twice (s1_twice),
    .s1_mid   (s1_mid),
    .s1_gain  (s1_gain),
    .s2_valid (s2_valid),
    .s2_prod  (s2_prod),
    .s2_mid   (s2_mid)
  );

  // stage 3: round, add back to centre, clamp
  vlap_round_clamp #(.PIX_W(PIX_W), .K_FRAC(K_FRAC), .PROD_W(PROD_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .s2_valid (s2_valid),
    .s2_prod  (s2_prod),
    .s2_mid   (s2_mid),
    .s3_valid (out_valid),
    .s3_pix   (pix_out)
  );

endmodule

// File: rtl/vlap_sharpen_chk.sv
module vlap_sharpen_chk #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned K_W   = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [PIX_W-1:0] pix_d1,
  input logic [K_W-1:0]   gain_k,
  input logic             out_valid,
  input logic [PIX_W-1:0] pix_out
);

  logic [1:0] cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc <= 2'd0;
    end else if (cyc != 2'd3) begin
      cyc <= cyc + 2'd1;
    end
  end

  a_r1_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  a_r6_zero_gain_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3 && $past(in_valid, 3) && $past(gain_k, 3) == '0)
      |-> (pix_out == $past(pix_d1, 3)));

  a_r4_full_centre_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3 && $past(in_valid, 3) && $past(pix_d1, 3) == {PIX_W{1'b1}})
      |-> (pix_out == {PIX_W{1'b1}}));

  a_r5_zero_centre_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3 && $past(in_valid, 3) && $past(pix_d1, 3) == '0)
      |-> (pix_out == '0));

  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != 2'd0 && !out_valid) |-> $stable(pix_out));

endmodule

bind vlap_sharpen vlap_sharpen_chk #(.PIX_W(PIX_W), .K_W(K_INT + K_FRAC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .in_valid  (in_valid),
  .pix_d1    (pix_d1),
  .gain_k    (gain_k),
  .out_valid (out_valid),
  .pix_out   (pix_out)
);

// File: tb/vlap_sharpen_tb.sv
module vlap_sharpen_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [7:0] pix_cur, pix_d1, pix_d2, gain_k;
  logic       out_valid;
  logic [7:0] pix_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  vlap_sharpen u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .pix_cur(pix_cur), .pix_d1(pix_d1), .pix_d2(pix_d2), .gain_k(gain_k),
    .out_valid(out_valid), .pix_out(pix_out)
  );

  function automatic int model(int a, int n, int b, int k);
    int p, r, v;
    p = (2 * n - a - b) * k;
    r = (p + 8) >>> 4;
    v = n + r;
    if (v < 0) v = 0;
    if (v > 255) v = 255;
    return v;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(bit v, int a, int n, int b, int k);
    in_valid = v;
    pix_d2   = 8'(a);
    pix_d1   = 8'(n);
    pix_cur  = 8'(b);
    gain_k   = 8'(k);
  endtask

  // one pixel, then idle; result checked exactly three clocks later
  task automatic t_single(string req, int a, int n, int b, int k);
    int exp;
    exp = model(a, n, b, k);
    @(negedge clk); drive(1, a, n, b, k);
    @(negedge clk); drive(0, 0, 0, 0, k);
    @(negedge clk);
    check(out_valid == 1'b0, "R1 early", int'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R1 latency", int'(out_valid), 1);
    check(int'(pix_out) == exp, req, int'(pix_out), exp);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    drive(0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R9 valid in reset", int'(out_valid), 0);
    check(pix_out == 8'd0, "R9 pix in reset", int'(pix_out), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R9 valid after release", int'(out_valid), 0);
    check(pix_out == 8'd0, "R9 pix after release", int'(pix_out), 0);
  endtask

  task automatic t_gain_late_change();
    // R7: gain drops to 0 one clock after the pixel is accepted
    @(negedge clk); drive(1, 60, 100, 80, 16);
    @(negedge clk); drive(0, 0, 0, 0, 0);
    @(negedge clk);
    @(negedge clk);
    check(out_valid && pix_out == 8'd160, "R7 gain of own cycle", int'(pix_out), 160);
  endtask

  task automatic t_hold();
    logic [7:0] last;
    t_single("R2 before hold", 30, 200, 90, 5);
    last = pix_out;
    @(negedge clk); drive(0, 255, 0, 255, 255);
    repeat (4) @(negedge clk);
    check(!out_valid && pix_out == last, "R8 hold while idle", int'(pix_out), int'(last));
  endtask

  task automatic t_stream();
    int ea[10];
    for (int i = 0; i < 13; i++) begin
      @(negedge clk);
      if (i >= 3) begin
        if (i - 3 < 10) begin
          check(out_valid == 1'b1, "R1 stream valid", int'(out_valid), 1);
          check(int'(pix_out) == ea[i-3], "R2 stream value", int'(pix_out), ea[i-3]);
        end
      end
      if (i < 10) begin
        ea[i] = model((i * 53) % 256, (i * 97 + 11) % 256, (i * 29 + 200) % 256, (i * 23) % 256);
        drive(1, (i * 53) % 256, (i * 97 + 11) % 256, (i * 29 + 200) % 256, (i * 23) % 256);
      end else begin
        drive(0, 0, 0, 0, 0);
      end
    end
    @(negedge clk);
    check(out_valid == 1'b0, "R1 stream drain", int'(out_valid), 0);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_single("R2 gain 1.5", 100, 120, 110, 24);
    t_single("R2 gain 0.75 negative", 90, 50, 70, 12);
    t_single("R3 half up", 10, 10, 9, 8);
    check(pix_out == 8'd11, "R3 +0.5 to +1", int'(pix_out), 11);
    t_single("R3 minus half", 10, 10, 11, 8);
    check(pix_out == 8'd10, "R3 -0.5 to 0", int'(pix_out), 10);
    t_single("R3 one and half", 9, 10, 8, 8);
    check(pix_out == 8'd12, "R3 +1.5 to +2", int'(pix_out), 12);
    t_single("R4 clamp high", 0, 255, 0, 16);
    t_single("R4 round then clamp", 20, 240, 30, 255);
    t_single("R5 clamp low", 255, 0, 255, 16);
    t_single("R5 round then clamp", 250, 15, 240, 200);
    t_single("R6 zero gain", 3, 77, 250, 0);
    check(pix_out == 8'd77, "R6 exact pass", int'(pix_out), 77);
    t_gain_late_change();
    t_hold();
    t_stream();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule